// File: doc/BRIEF.md
# Dual-Issue In-Order Issue Controller

This block decides when decoded instructions leave decode and start executing in a two-wide pipeline. Issue and result write-back both follow program order. Decoded instructions arrive as a pair. Slot A holds the older instruction and slot B the younger. Each instruction carries a destination register, up to two optional source registers, a class bit (integer or floating-point) and an execute latency.

The controller owns three execution units: two integer units and one floating-point unit. Each unit is modelled only as a countdown loaded with the instruction's latency. The controller keeps one busy bit per architectural register. It holds back an instruction that would read a value still in flight, overwrite a register with a pending write, find no free unit of its class, or finish before an older instruction. Finished results leave through two write-back ports. A flush input clears all tracking state in one edge.

Top module: `dual_issue_ctl`

## Requirements
- R1: `in_ready` is high exactly when both decode slots are empty. A pair presented with `in_valid` high while `in_ready` is high is captured at that clock edge.
- R2: Slot B never issues before slot A. B may issue in the same cycle as A only if neither of B's enabled sources and not B's destination equals A's destination. Otherwise B waits for a later cycle.
- R3: Unit codes on the issue ports are 0 and 1 for the integer units and 2 for the floating-point unit. An integer instruction takes unit 0 when it is free, else unit 1. An instruction stalls while no unit of its class has a zero countdown.
- R4: An instruction stalls while any of its enabled sources is marked busy. A register's busy bit is set when an instruction that writes it issues. It is cleared at the end of that instruction's write-back cycle.
- R5: An instruction stalls while its destination register is marked busy.
- R6: An instruction issues only if its latency is at least the remaining countdown of every unit. Slot B issues together with A only if B's latency is at least A's. As a result, results complete in program order and at most two complete per cycle.
- R7: An instruction issued in cycle T with latency L (from 1 to 2^LW-1) is written back in cycle T+L. A lone result uses port 0. When both instructions of a pair finish in the same cycle, A uses port 0 and B uses port 1.
- R8: A flush clears both decode slots, all countdowns and all busy bits at one edge. No result from an instruction issued before the flush is written back afterwards.
- R9: After reset, `in_ready` is high and no issue or write-back is signalled.
- R10: An independent pair is captured into decode at one edge and issues entirely in the next cycle when three conditions hold: both units of its classes are free, B's latency is at least A's, and no register hazard exists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Clear decode slots and all in-flight tracking |
| in_valid | input | 1 | A decoded pair is offered |
| in_ready | output | 1 | Both decode slots are empty |
| a_dst | input | RW | Older instruction destination register |
| a_src0 | input | RW | Older instruction first source |
| a_src0_en | input | 1 | First source of A is used |
| a_src1 | input | RW | Older instruction second source |
| a_src1_en | input | 1 | Second source of A is used |
| a_fp | input | 1 | A is floating-point (1) or integer (0) |
| a_lat | input | LW | A execute latency, 1 or more |
| b_dst | input | RW | Younger instruction destination register |
| b_src0 | input | RW | Younger instruction first source |
| b_src0_en | input | 1 | First source of B is used |
| b_src1 | input | RW | Younger instruction second source |
| b_src1_en | input | 1 | Second source of B is used |
| b_fp | input | 1 | B is floating-point (1) or integer (0) |
| b_lat | input | LW | B execute latency, 1 or more |
| iss0 | output | 1 | Slot A issues this cycle |
| iss0_unit | output | 2 | Unit taken by A |
| iss1 | output | 1 | Slot B issues this cycle |
| iss1_unit | output | 2 | Unit taken by B |
| wb0_valid | output | 1 | Write-back port 0 carries a result |
| wb0_reg | output | RW | Register written on port 0 |
| wb1_valid | output | 1 | Write-back port 1 carries a result |
| wb1_reg | output | RW | Register written on port 1 |

## Verification
Several properties are checked on every cycle. The assertions check that no issue is signalled while decode is empty, that B never issues alone while A is still waiting, and that a destination is marked busy right after its instruction issues. They also check that port 1 is never used without port 0, that no more than two units finish together, and that a flush leaves no result pending. Exact issue and write-back cycles can only be shown by the bench's scenarios. These include a sweep over every pair of latencies from 1 to 4, and directed cases for read-after-write within a pair, write-after-write, floating-point unit contention, both integer units busy, and flush.

// File: rtl/dual_issue_ctl.sv
`timescale 1ns/1ps
module dual_issue_ctl #(
  parameter int NREG = 32,
  parameter int LW = 3,
  localparam int RW = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [RW-1:0] a_dst,
  input  logic [RW-1:0] a_src0,
  input  logic          a_src0_en,
  input  logic [RW-1:0] a_src1,
  input  logic          a_src1_en,
  input  logic          a_fp,
  input  logic [LW-1:0] a_lat,
  input  logic [RW-1:0] b_dst,
  input  logic [RW-1:0] b_src0,
  input  logic          b_src0_en,
  input  logic [RW-1:0] b_src1,
  input  logic          b_src1_en,
  input  logic          b_fp,
  input  logic [LW-1:0] b_lat,
  output logic          iss0,
  output logic [1:0]    iss0_unit,
  output logic          iss1,
  output logic [1:0]    iss1_unit,
  output logic          wb0_valid,
  output logic [RW-1:0] wb0_reg,
  output logic          wb1_valid,
  output logic [RW-1:0] wb1_reg
);
  localparam int NU = 3;

  logic [1:0]      v, sae, sbe, sfp;
  logic [RW-1:0]   sd [2];
  logic [RW-1:0]   sa [2];
  logic [RW-1:0]   sb [2];
  logic [LW-1:0]   sl [2];
  logic [NREG-1:0] busy, clr, set;
  logic [LW-1:0]   cnt [NU];
  logic [RW-1:0]   ud [NU];
  logic [NU-1:0]   yng, free, fin;
  logic [LW-1:0]   maxc;
  logic [1:0]      solo, usel0, usel1;
  logic            pair_ok, go0, go1;

  always_comb begin
    maxc = '0;
    for (int u = 0; u < NU; u++) begin
      free[u] = (cnt[u] == '0);
      fin[u]  = (cnt[u] == LW'(1));
      if (cnt[u] > maxc) maxc = cnt[u];
    end
    for (int s = 0; s < 2; s++)
      solo[s] = v[s] && !(sae[s] && busy[sa[s]]) && !(sbe[s] && busy[sb[s]]) &&
                !busy[sd[s]] && (sl[s] >= maxc) && (sfp[s] ? free[2] : |free[1:0]);
  end

  assign in_ready = ~|v;
  assign usel0 = sfp[0] ? 2'd2 : (free[0] ? 2'd0 : 2'd1);
  assign go0 = !flush && solo[0];
  assign pair_ok = !(sae[1] && sa[1] == sd[0]) && !(sbe[1] && sb[1] == sd[0]) &&
                   (sd[1] != sd[0]) && (sl[1] >= sl[0]) &&
                   (sfp[1] ? !sfp[0] : (sfp[0] || &free[1:0]));
  assign go1 = !flush && solo[1] && (!v[0] || (go0 && pair_ok));
  assign usel1 = sfp[1] ? 2'd2 : ((go0 && !sfp[0]) ? 2'd1 : (free[0] ? 2'd0 : 2'd1));

  assign iss0 = go0;
  assign iss1 = go1;
  assign iss0_unit = usel0;
  assign iss1_unit = usel1;

  always_comb begin
    wb0_valid = 1'b0; wb0_reg = '0; wb1_valid = 1'b0; wb1_reg = '0;
    clr = '0; set = '0;
    for (int u = 0; u < NU; u++) begin
      if (fin[u]) clr[ud[u]] = 1'b1;
      if (fin[u] && !yng[u]) begin wb0_valid = 1'b1; wb0_reg = ud[u]; end
      if (fin[u] && yng[u])  begin wb1_valid = 1'b1; wb1_reg = ud[u]; end
    end
    if (go0) set[sd[0]] = 1'b1;
    if (go1) set[sd[1]] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (in_valid && in_ready) begin
      sd[0] <= a_dst; sa[0] <= a_src0; sb[0] <= a_src1; sl[0] <= a_lat;
      sd[1] <= b_dst; sa[1] <= b_src0; sb[1] <= b_src1; sl[1] <= b_lat;
    end
    for (int u = 0; u < NU; u++)
      if (go0 && int'(usel0) == u) ud[u] <= sd[0];
      else if (go1 && int'(usel1) == u) ud[u] <= sd[1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v <= '0; sae <= '0; sbe <= '0; sfp <= '0; busy <= '0; yng <= '0;
      for (int u = 0; u < NU; u++) cnt[u] <= '0;
    end else if (flush) begin
      v <= '0; busy <= '0; yng <= '0;
      for (int u = 0; u < NU; u++) cnt[u] <= '0;
    end else begin
      if (in_valid && in_ready) begin
        v <= 2'b11;
        sae <= {b_src0_en, a_src0_en}; sbe <= {b_src1_en, a_src1_en}; sfp <= {b_fp, a_fp};
      end else begin
        if (go0) v[0] <= 1'b0;
        if (go1) v[1] <= 1'b0;
      end
      for (int u = 0; u < NU; u++) begin
        if (go0 && int'(usel0) == u) begin
          cnt[u] <= sl[0]; yng[u] <= 1'b0;
        end else if (go1 && int'(usel1) == u) begin
          cnt[u] <= sl[1]; yng[u] <= go0 && (sl[1] == sl[0]);
        end else if (cnt[u] != '0) begin
          cnt[u] <= cnt[u] - LW'(1);
        end
      end
      busy <= (busy & ~clr) | set;
    end
  end

  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !iss0 && !iss1); // R1
  AST_SLOT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    iss1 && !iss0 |-> !v[0]); // R2
  AST_BUSY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    iss0 |=> busy[$past(sd[0])]); // R4
  AST_TWO_WB: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(fin) <= 2); // R6
  AST_WB_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    wb1_valid |-> wb0_valid); // R7
  AST_FLUSH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> in_ready && !wb0_valid && !wb1_valid); // R8
endmodule

// File: tb/sim_dual_issue_ctl.sv
`timescale 1ns/1ps
module sim_dual_issue_ctl;
  logic clk = 0, rst_n = 0, flush = 0, in_valid = 0;
  logic in_ready, iss0, iss1, wb0_valid, wb1_valid;
  logic [1:0] iss0_unit, iss1_unit;
  logic [4:0] a_dst, a_src0, a_src1, b_dst, b_src0, b_src1, wb0_reg, wb1_reg;
  logic a_src0_en, a_src1_en, a_fp, b_src0_en, b_src1_en, b_fp;
  logic [2:0] a_lat, b_lat;
  int checks = 0, failures = 0;
  int t_i0, t_i1, u_i0, u_i1;
  int wbt [32];
  int wbp [32];
  int rdy [16];

  always #5 clk = ~clk;

  dual_issue_ctl u0 (.*);

  task automatic check(int act, int exp, string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", what, act, exp);
    end
  endtask

  task automatic pa(int d, int s0, int s1, bit f, int l);
    a_dst = 5'(d); a_src0 = 5'(s0 < 0 ? 0 : s0); a_src0_en = s0 >= 0;
    a_src1 = 5'(s1 < 0 ? 0 : s1); a_src1_en = s1 >= 0; a_fp = f; a_lat = 3'(l);
  endtask

  task automatic pb(int d, int s0, int s1, bit f, int l);
    b_dst = 5'(d); b_src0 = 5'(s0 < 0 ? 0 : s0); b_src0_en = s0 >= 0;
    b_src1 = 5'(s1 < 0 ? 0 : s1); b_src1_en = s1 >= 0; b_fp = f; b_lat = 3'(l);
  endtask

  task automatic run(int ncyc);
    in_valid = 1;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    in_valid = 0;
    t_i0 = -1; t_i1 = -1; u_i0 = -1; u_i1 = -1;
    for (int r = 0; r < 32; r++) begin wbt[r] = -1; wbp[r] = -1; end
    for (int k = 1; k <= ncyc; k++) begin
      @(negedge clk); #1;
      rdy[k] = int'(in_ready);
      if (iss0 && t_i0 < 0) begin t_i0 = k; u_i0 = int'(iss0_unit); end
      if (iss1 && t_i1 < 0) begin t_i1 = k; u_i1 = int'(iss1_unit); end
      if (wb0_valid && wbt[wb0_reg] < 0) begin wbt[wb0_reg] = k; wbp[wb0_reg] = 0; end
      if (wb1_valid && wbt[wb1_reg] < 0) begin wbt[wb1_reg] = k; wbp[wb1_reg] = 1; end
    end
  endtask

  task automatic finish_up();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL R1 watchdog act=0 exp=1");
    finish_up();
  end

  initial begin
    pa(0, -1, -1, 0, 1); pb(0, -1, -1, 0, 1);
    repeat (2) @(negedge clk);
    #1;
    check(int'(in_ready), 1, "R9 ready after reset");
    check(int'(iss0 | iss1), 0, "R9 no issue in reset");
    check(int'(wb0_valid | wb1_valid), 0, "R9 no write-back in reset");
    rst_n = 1;
    @(negedge clk);

    // r6_ / r7_ / r10_ sweep over latency pairs, independent integer pair
    for (int la = 1; la <= 4; la++)
      for (int lb = 1; lb <= 4; lb++) begin
        pa(1, -1, -1, 0, la); pb(2, -1, -1, 0, lb);
        run(10);
        check(t_i0, 1, "R10 A issues next cycle");
        check(wbt[1], 1 + la, "R7 A write-back cycle");
        check(wbp[1], 0, "R7 A port");
        if (lb >= la) begin
          check(t_i1, 1, "R10 B dual issue");
          check(u_i1, 1, "R3 B takes second integer unit");
          check(wbt[2], 1 + lb, "R7 B write-back cycle");
          check(wbp[2], (la == lb) ? 1 : 0, "R7 B port");
        end else begin
          check(t_i1, la - lb + 2, "R6 B held for order");
          check(wbt[2], la + 2, "R6 B completes after A");
          check(wbp[2], 0, "R7 B lone port");
        end
      end

    // R2 / R4: B reads A's destination
    pa(3, -1, -1, 0, 1); pb(4, -1, 3, 0, 1);
    run(4);
    check(t_i0, 1, "R2 A issues");
    check(t_i1, 3, "R4 B waits for A write-back");
    check(rdy[2], 0, "R1 ready low while B pending");
    check(rdy[4], 1, "R1 ready high once both issued");

    // R5: write-after-write on register 4
    pa(4, -1, -1, 0, 2); pb(4, -1, -1, 0, 3);
    run(8);
    check(wbt[4], 3, "R5 A write-back");
    check(t_i1, 4, "R5 B waits for destination");

    // R3: floating-point contention
    pa(20, -1, -1, 1, 1); pb(21, -1, -1, 1, 1);
    run(6);
    check(u_i0, 2, "R3 A on float unit");
    check(t_i1, 3, "R3 B waits for float unit");
    check(u_i1, 2, "R3 B on float unit");
    check(wbt[21], 4, "R7 B float write-back");

    // R3: both integer units busy
    pa(5, -1, -1, 0, 3); pb(6, -1, -1, 0, 3);
    run(1);
    check(u_i0, 0, "R3 A on integer unit 0");
    check(u_i1, 1, "R3 B on integer unit 1");
    pa(7, -1, -1, 0, 1); pb(8, -1, -1, 0, 1);
    run(5);
    check(wbt[5], 2, "R7 older pair port0");
    check(wbp[6], 1, "R7 older pair younger on port1");
    check(t_i0, 3, "R3 waits for free integer unit");
    check(t_i1, 3, "R10 second pair dual issue");
    check(wbt[8], 4, "R7 second pair write-back");

    // R8: flush
    pa(2, -1, -1, 0, 4); pb(9, -1, -1, 0, 4);
    run(1);
    pa(10, 2, -1, 0, 1); pb(11, -1, -1, 0, 1);
    run(1);
    check(t_i0, -1, "R4 stalled on in-flight source");
    flush = 1;
    @(negedge clk); flush = 0; #1;
    check(int'(in_ready), 1, "R8 decode empty after flush");
    for (int k = 0; k < 4; k++) begin
      check(int'(wb0_valid | wb1_valid), 0, "R8 no write-back after flush");
      @(negedge clk); #1;
    end
    pa(12, 2, -1, 0, 1); pb(13, -1, -1, 0, 1);
    run(3);
    check(t_i0, 1, "R8 busy bits cleared");
    check(t_i1, 1, "R8 units cleared");
    finish_up();
  end
endmodule